// File: doc/BRIEF.md
# Sampled LRU Utility Monitor

This block sits beside one core and estimates how much that core would gain from each additional way of a shared 16-way cache. It keeps a shadow tag directory, private to the core and separate from the cache's real tags. The directory covers only a sampled subset of 32 sets and keeps exact least-recently-used order in each of them. Every access that hits in the shadow directory increments a counter for the recency position where the tag was found. Position 0 is the most recently used entry and position 15 the least recently used.

Because true LRU is a stack algorithm, the hits the core would get with n ways equal the sum of counters 0 through n-1. A readout port gives one counter and this running sum for any index. A partitioning engine reads them once per epoch and then pulses the halving strobe. The strobe halves every counter, so older behaviour counts for less over time. The shadow directory and counters together hold 6912 bits, which is under 2 kB per core.

Top module: `umon_sampled_lru`

## Requirements
- R1: After reset all sixteen counters read zero and every shadow entry is invalid.
- R2: A set index is sampled only when its low SET_W-5 bits are zero, and its upper 5 bits choose the shadow set. An access to any other set changes neither the directory nor any counter.
- R3: An access that finds its tag at recency position p (0 = MRU, 15 = LRU) adds one to counter p. The new value is visible on the read port from the clock edge that samples the access.
- R4: On a hit the matching entry becomes MRU. The entries that were more recent than it each move one position deeper, and deeper entries keep their places.
- R5: On a miss the new tag is written at MRU, every other entry moves one position deeper, the entry at position 15 is dropped, and no counter changes.
- R6: Each shadow set holds 16 ways. A tag followed by 15 distinct other tags in the same set hits at position 15. After 16 distinct other tags it misses.
- R7: Counters are 16 bits wide and stay at 65535 once they reach it.
- R8: A halving pulse sets every counter to floor(value/2). If a hit arrives in the same cycle, the halving is applied first and the increment after it.
- R9: rd_cum_hits equals the sum of counters 0 through rd_idx, which is the hit count for rd_idx+1 ways.
- R10: One access is accepted every cycle. Back-to-back accesses to the same set each see the order left by the previous access.
- R11: An invalid entry never produces a hit, even when its stored tag bits equal the access tag (tag 0 on a fresh set misses).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_vld | input | 1 | Access from the core is present this cycle |
| acc_set | input | SET_W | Set index of the access in the shared cache |
| acc_tag | input | TAG_W | Tag of the access |
| epoch_halve | input | 1 | Halve every counter at this edge |
| rd_idx | input | log2(WAYS) | Recency position to read |
| rd_hits | output | CNT_W | Counter for position rd_idx |
| rd_cum_hits | output | CNT_W+log2(WAYS) | Sum of counters 0 through rd_idx |

## Verification
The assertions check the following on every cycle:
- Unsampled accesses never reach the directory.
- Tags inside a shadow set never match twice.
- Every accepted access leaves its tag at MRU.
- A saturated counter never wraps.
- Halving never leaves a counter above half its old value plus one.
- Counters hold still when there is no hit and no halving.

Only the bench scenarios can show the rest. This covers the exact stack reordering for hits at each depth and eviction after sixteen distinct tags. It also covers tag 0 missing on fresh sets, halving combined with a hit in the same cycle, and the correctness of the running sum against a separate behavioural queue model.

// File: rtl/umon_pkg.sv
package umon_pkg;
    localparam int unsigned UMON_WAYS   = 16;
    localparam int unsigned UMON_SAMP_W = 5;
    localparam int unsigned UMON_SET_W  = 10;
    localparam int unsigned UMON_TAG_W  = 12;
    localparam int unsigned UMON_CNT_W  = 16;

    // Outcome of one shadow lookup
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_MISS = 2'd1,
        LK_HIT  = 2'd2
    } lk_kind_e;
endpackage

// File: rtl/umon_sample_decode.sv
module umon_sample_decode #(
    parameter int unsigned SET_W  = 10,
    parameter int unsigned SAMP_W = 5
) (
    input  logic [SET_W-1:0]  set_idx,
    output logic              sampled,
    output logic [SAMP_W-1:0] slot
);
    localparam int unsigned STRIDE_W = SET_W - SAMP_W;

    generate
        if (STRIDE_W == 0) begin : g_every_set
            assign sampled = 1'b1;
            assign slot    = set_idx;
        end else begin : g_strided
            // one set in every 2**STRIDE_W is shadowed
            assign sampled = (set_idx[STRIDE_W-1:0] == '0);
            assign slot    = set_idx[SET_W-1:STRIDE_W];
        end
    endgenerate
endmodule

// File: rtl/umon_dir.sv
module umon_dir
    import umon_pkg::*;
#(
    parameter int unsigned WAYS   = 16,
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned TAG_W  = 12,
    localparam int unsigned WAY_W  = $clog2(WAYS),
    localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_vld,
    input  logic [SLOT_W-1:0] acc_slot,
    input  logic [TAG_W-1:0]  acc_tag,
    output lk_kind_e          lk_kind,
    output logic [WAY_W-1:0]  lk_pos
);
    // Each shadow set is kept in stack order: index 0 = MRU
    typedef struct packed {
        logic [SLOTS-1:0][WAYS-1:0]            vld;
        logic [SLOTS-1:0][WAYS-1:0][TAG_W-1:0] tag;
    } dir_t;

    dir_t dir_d, dir_q;
    logic [WAYS-1:0] match;

    always_comb begin
        logic found;
        found  = 1'b0;
        lk_pos = '0;
        for (int w = 0; w < WAYS; w++) begin
            match[w] = dir_q.vld[acc_slot][w] && (dir_q.tag[acc_slot][w] == acc_tag);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (match[w] && !found) begin
                lk_pos = WAY_W'(w);
                found  = 1'b1;
            end
        end
        if (!acc_vld)     lk_kind = LK_IDLE;
        else if (found)   lk_kind = LK_HIT;
        else              lk_kind = LK_MISS;
    end

    always_comb begin
        dir_d = dir_q;
        if (lk_kind == LK_HIT) begin
            for (int w = WAYS - 1; w > 0; w--) begin
                if (w <= int'(lk_pos)) begin
                    dir_d.vld[acc_slot][w] = dir_q.vld[acc_slot][w-1];
                    dir_d.tag[acc_slot][w] = dir_q.tag[acc_slot][w-1];
                end
            end
            dir_d.vld[acc_slot][0] = 1'b1;
            dir_d.tag[acc_slot][0] = acc_tag;
        end else if (lk_kind == LK_MISS) begin
            for (int w = WAYS - 1; w > 0; w--) begin
                dir_d.vld[acc_slot][w] = dir_q.vld[acc_slot][w-1];
                dir_d.tag[acc_slot][w] = dir_q.tag[acc_slot][w-1];
            end
            dir_d.vld[acc_slot][0] = 1'b1;
            dir_d.tag[acc_slot][0] = acc_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dir_q <= '0;
        else        dir_q <= dir_d;
    end

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld |-> $onehot0(match)); // R4

    AST_MRU_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_kind != LK_IDLE) |=> (dir_q.vld[$past(acc_slot)][0]
                                  && dir_q.tag[$past(acc_slot)][0] == $past(acc_tag))); // R5
endmodule

// File: rtl/umon_counters.sv
module umon_counters #(
    parameter int unsigned WAYS  = 16,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned CUM_W = CNT_W + WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_vld,
    input  logic [WAY_W-1:0] inc_pos,
    input  logic             halve,
    input  logic [WAY_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [CUM_W-1:0] rd_cum
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [WAYS-1:0][CNT_W-1:0] h;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        logic [CNT_W-1:0] v;
        ctr_d = ctr_q;
        for (int w = 0; w < WAYS; w++) begin
            v = halve ? (ctr_q.h[w] >> 1) : ctr_q.h[w];
            if (inc_vld && (int'(inc_pos) == w) && (v != CNT_MAX)) begin
                v = v + 1'b1;
            end
            ctr_d.h[w] = v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    always_comb begin
        rd_cnt = ctr_q.h[rd_idx];
        rd_cum = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (w <= int'(rd_idx)) begin
                rd_cum = rd_cum + {{WAY_W{1'b0}}, ctr_q.h[w]};
            end
        end
    end

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_vld && !halve) |=> $stable(ctr_q.h)); // R5

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_chk
            AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                (inc_vld && !halve && int'(inc_pos) == g && ctr_q.h[g] == CNT_MAX)
                |=> (ctr_q.h[g] == CNT_MAX)); // R7

            AST_HALVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                halve |=> ({1'b0, ctr_q.h[g]} <= {1'b0, $past(ctr_q.h[g]) >> 1} + 1'b1)); // R8
        end
    endgenerate
endmodule

// File: rtl/umon_sampled_lru.sv
module umon_sampled_lru
    import umon_pkg::*;
#(
    parameter int unsigned SET_W  = UMON_SET_W,
    parameter int unsigned TAG_W  = UMON_TAG_W,
    parameter int unsigned WAYS   = UMON_WAYS,
    parameter int unsigned SAMP_W = UMON_SAMP_W,
    parameter int unsigned CNT_W  = UMON_CNT_W,
    localparam int unsigned WAY_W = $clog2(WAYS),
    localparam int unsigned SLOTS = 1 << SAMP_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_vld,
    input  logic [SET_W-1:0]       acc_set,
    input  logic [TAG_W-1:0]       acc_tag,
    input  logic                   epoch_halve,
    input  logic [WAY_W-1:0]       rd_idx,
    output logic [CNT_W-1:0]       rd_hits,
    output logic [CNT_W+WAY_W-1:0] rd_cum_hits
);
    logic              sampled;
    logic [SAMP_W-1:0] slot;
    lk_kind_e          lk_kind;
    logic [WAY_W-1:0]  lk_pos;

    umon_sample_decode #(.SET_W(SET_W), .SAMP_W(SAMP_W)) u_decode (
        .set_idx (acc_set),
        .sampled (sampled),
        .slot    (slot)
    );

    umon_dir #(.WAYS(WAYS), .SLOTS(SLOTS), .TAG_W(TAG_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_vld  (acc_vld && sampled),
        .acc_slot (slot),
        .acc_tag  (acc_tag),
        .lk_kind  (lk_kind),
        .lk_pos   (lk_pos)
    );

    umon_counters #(.WAYS(WAYS), .CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_vld (lk_kind == LK_HIT),
        .inc_pos (lk_pos),
        .halve   (epoch_halve),
        .rd_idx  (rd_idx),
        .rd_cnt  (rd_hits),
        .rd_cum  (rd_cum_hits)
    );

    AST_UNSAMPLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !sampled) |-> (lk_kind == LK_IDLE)); // R2
endmodule

// File: tb/tb_umon_sampled_lru.sv
`timescale 1ns/1ps
module tb_umon_sampled_lru;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_vld = 1'b0;
    logic [9:0]  acc_set = '0;
    logic [11:0] acc_tag = '0;
    logic        epoch_halve = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_hits;
    logic [19:0] rd_cum_hits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int stk[32][$];
    int h[16];

    always #4 clk = ~clk;

    umon_sampled_lru dut (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
        .acc_tag(acc_tag), .epoch_halve(epoch_halve), .rd_idx(rd_idx),
        .rd_hits(rd_hits), .rd_cum_hits(rd_cum_hits)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int cum(int r);
        int s = 0;
        for (int i = 0; i <= r; i++) s += h[i];
        return s;
    endfunction

    task automatic model(bit v, int s, int t, bit ep);
        int sl;
        int p;
        if (ep) for (int i = 0; i < 16; i++) h[i] = h[i] / 2;
        if (v && (s % 32 == 0)) begin
            sl = s / 32;
            p = -1;
            for (int i = 0; i < stk[sl].size(); i++) if (stk[sl][i] == t && p < 0) p = i;
            if (p >= 0) begin
                if (h[p] < 65535) h[p]++;
                stk[sl].delete(p);
            end
            stk[sl].push_front(t);
            if (stk[sl].size() > 16) void'(stk[sl].pop_back());
        end
    endtask

    task automatic step(bit v, int s, int t, bit ep, int r, string req);
        @(negedge clk);
        acc_vld = v; acc_set = 10'(s); acc_tag = 12'(t); epoch_halve = ep; rd_idx = 4'(r);
        #1;
        chk(req, int'(rd_hits), h[r]);
        chk({req, " R9"}, int'(rd_cum_hits), cum(r));
        @(posedge clk);
        model(v, s, t, ep);
    endtask

    task automatic peek(int r, int exp, string req);
        @(negedge clk);
        acc_vld = 1'b0; epoch_halve = 1'b0; rd_idx = 4'(r);
        #1;
        chk(req, int'(rd_hits), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) h[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: every counter zero after reset
        for (int r = 0; r < 16; r++) peek(r, 0, "R1");

        // R11: tag 0 on a fresh set misses, then hits at MRU
        step(1, 0, 0, 0, 0, "R11");
        peek(0, 0, "R11");
        step(1, 0, 0, 0, 0, "R11");
        peek(0, 1, "R3");

        // R6 / R5: fill set 32 with 16 tags, oldest sits at position 15
        for (int t = 1; t <= 16; t++) step(1, 32, t, 0, 15, "R5");
        step(1, 32, 1, 0, 15, "R6");
        peek(15, 1, "R6");
        step(1, 32, 50, 0, 15, "R5");   // evicts tag 2
        step(1, 32, 2, 0, 15, "R6");    // must miss
        peek(15, 1, "R6");
        for (int r = 0; r < 16; r++) peek(r, h[r], "R5");

        // R4: hits at several depths reorder the stack
        step(1, 32, 9, 0, 0, "R4");
        step(1, 32, 5, 0, 0, "R4");
        step(1, 32, 9, 0, 0, "R4");
        step(1, 32, 16, 0, 0, "R4");
        step(1, 32, 5, 0, 2, "R4");
        for (int r = 0; r < 16; r++) step(0, 0, 0, 0, r, "R4");

        // R2: unsampled sets, same tags, change nothing
        for (int i = 0; i < 20; i++) step(1, 33 + i, 5 + (i % 3), 0, i % 16, "R2");
        step(1, 1, 0, 0, 0, "R2");
        step(1, 32, 9, 0, 1, "R2");
        step(1, 0, 0, 0, 0, "R2");
        for (int r = 0; r < 16; r++) step(0, 0, 0, 0, r, "R2");

        // R10: back-to-back alternating tags in one set
        for (int i = 0; i < 12; i++) step(1, 64, (i % 2) ? 300 : 301, 0, 1, "R10");
        step(0, 0, 0, 0, 1, "R10");

        // R8: halving alone, then halving with a hit in the same cycle
        step(0, 0, 0, 1, 1, "R8");
        step(1, 64, 300, 1, 1, "R8");
        for (int r = 0; r < 16; r++) step(0, 0, 0, 0, r, "R8");

        // R3 / R9: mixed traffic compared on every clock
        for (int i = 0; i < 4000; i++) begin
            int s;
            s = ($urandom % 4 != 0) ? 32 * ($urandom % 3) : int'($urandom % 1024);
            step($urandom % 5 != 0, s, int'($urandom % 20), ($urandom % 300) == 0,
                 int'($urandom % 16), "R3");
        end
        for (int r = 0; r < 16; r++) step(0, 0, 0, 0, r, "R9");

        // R7: saturation of the MRU counter
        step(0, 0, 0, 1, 0, "R7");
        for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, "R7");
        for (int i = 0; i < 65600; i++) step(1, 96, 7, 0, 0, "R7");
        peek(0, 65535, "R7");
        step(1, 96, 7, 0, 0, "R7");
        peek(0, 65535, "R7");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule